// File: doc/BRIEF.md
# Transmit Frame Assembler

This block builds one fixed-length transmit frame per start request and sends it as a serial bit stream with valid/ready flow control. The frame has 64 bits in a fixed order. First come 48 information bits taken one at a time from an upstream source. Next come a 4-bit signalling constant 1011, then a 4-bit dummy constant 0011. Last come 8 zero bits, which return a downstream trellis encoder to its all-zero state.

While the information field is being sent, the block passes each upstream bit straight to the output. The upstream handshake is tied to the downstream one, so the stream stalls whenever either side is not ready. During the constant fields the block produces the bits itself and keeps upstream ready low. The output flags the first and the last bit of every frame. A start request that arrives while a frame is in progress is dropped.

Top module: `tx_frame_asm`

## Requirements
- R1: After reset, and whenever no frame is in progress, out_valid_o, in_ready_o, out_first_o and out_last_o are low.
- R2: When no frame is in progress, a high sof_i at a clock edge starts a frame. From the following cycle the block presents frame bit 0, and a frame is exactly 64 accepted output bits.
- R3: Frame bits 0..47 are the information bits, in the order they were accepted at the input. in_ready_o is high only during these positions, and only while out_ready_i is high.
- R4: Frame bits 48..51 are the signalling constant 1011, sent MSB first (1, 0, 1, 1).
- R5: Frame bits 52..55 are the dummy constant 0011, sent MSB first (0, 0, 1, 1).
- R6: Frame bits 56..63 are all zero.
- R7: out_first_o is high exactly while frame bit 0 is presented. out_last_o is high exactly while frame bit 63 is presented.
- R8: During the information field, out_valid_o follows in_valid_i. A cycle without valid input does not advance the frame.
- R9: While out_valid_o is high and out_ready_i is low, the frame does not advance, and during constant fields the presented bit stays the same.
- R10: A sof_i pulse during a frame, including during its last bit, has no effect. The frame still ends after bit 63, and the block then stays idle until a new sof_i arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame request |
| in_bit_i | input | 1 | Information bit from upstream |
| in_valid_i | input | 1 | Upstream bit valid |
| in_ready_o | output | 1 | Block accepts an information bit |
| out_bit_o | output | 1 | Serial frame bit |
| out_valid_o | output | 1 | Output bit valid |
| out_ready_i | input | 1 | Downstream accepts the bit |
| out_first_o | output | 1 | Frame bit 0 presented |
| out_last_o | output | 1 | Frame bit 63 presented |

## Verification
The hardest case to reach from the ports is a start request that lands inside a running frame, worst of all on the cycle its last bit is accepted, while both handshakes are stalling. The bench therefore runs one pattern with irregular input gaps and irregular downstream back-pressure together. During that pattern it pulses sof_i at a mid-frame position and again on every cycle bit 63 is presented. The bench then confirms that the frame length is unchanged and that the output stays silent afterwards. Every bit position is compared against a model of the field layout, under each combination of stall patterns.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  typedef enum logic [1:0] {
    FLD_DATA  = 2'd0,
    FLD_SIG   = 2'd1,
    FLD_DUMMY = 2'd2,
    FLD_FLUSH = 2'd3
  } tfa_field_e;
endpackage

// File: rtl/tfa_seq.sv
module tfa_seq #(
  parameter int FRAME_BITS = 64,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             adv_i,
  output logic             busy_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic             busy_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (!busy_q) begin
      if (sof_i) begin
        busy_q <= 1'b1;
        pos_q  <= '0;
      end
    end else if (adv_i) begin
      if (pos_q == LAST_POS) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign pos_o  = pos_q;

  p_no_adv_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !sof_i |=> !busy_q);
  p_hold_pos_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !adv_i |=> busy_q && $stable(pos_q));
endmodule

// File: rtl/tfa_field_dec.sv
module tfa_field_dec
  import tfa_pkg::*;
#(
  parameter int DATA_BITS  = 48,
  parameter int SIG_BITS   = 4,
  parameter int DUMMY_BITS = 4,
  parameter int FLUSH_BITS = 8,
  localparam int FRAME_BITS = DATA_BITS + SIG_BITS + DUMMY_BITS + FLUSH_BITS,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic [POS_W-1:0] pos_i,
  output tfa_field_e       field_o
);
  localparam logic [POS_W-1:0] SIG_START   = POS_W'(DATA_BITS);
  localparam logic [POS_W-1:0] DUMMY_START = POS_W'(DATA_BITS + SIG_BITS);
  localparam logic [POS_W-1:0] FLUSH_START = POS_W'(DATA_BITS + SIG_BITS + DUMMY_BITS);

  always_comb begin
    if (pos_i < SIG_START)        field_o = FLD_DATA;
    else if (pos_i < DUMMY_START) field_o = FLD_SIG;
    else if (pos_i < FLUSH_START) field_o = FLD_DUMMY;
    else                          field_o = FLD_FLUSH;
  end
endmodule

// File: rtl/tfa_bit_mux.sv
module tfa_bit_mux
  import tfa_pkg::*;
#(
  parameter int DATA_BITS  = 48,
  parameter int SIG_BITS   = 4,
  parameter int DUMMY_BITS = 4,
  parameter int FLUSH_BITS = 8,
  parameter logic [SIG_BITS-1:0]   SIG_VAL   = 4'b1011,
  parameter logic [DUMMY_BITS-1:0] DUMMY_VAL = 4'b0011,
  localparam int FRAME_BITS = DATA_BITS + SIG_BITS + DUMMY_BITS + FLUSH_BITS,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int TAIL_W = SIG_BITS + DUMMY_BITS + FLUSH_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [POS_W-1:0] pos_i,
  input  tfa_field_e       field_i,
  input  logic             in_bit_i,
  input  logic             in_valid_i,
  output logic             out_bit_o,
  output logic             out_valid_o
);
  localparam logic [POS_W-1:0] DATA_END = POS_W'(DATA_BITS);

  // constant tail, MSB = first transmitted
  logic [TAIL_W-1:0] tail;
  genvar gi;
  generate
    for (gi = 0; gi < TAIL_W; gi++) begin : g_tail
      if (gi >= TAIL_W - SIG_BITS) begin : g_sig
        assign tail[gi] = SIG_VAL[gi - (TAIL_W - SIG_BITS)];
      end else if (gi >= FLUSH_BITS) begin : g_dmy
        assign tail[gi] = DUMMY_VAL[gi - FLUSH_BITS];
      end else begin : g_fl
        assign tail[gi] = 1'b0;
      end
    end
  endgenerate

  logic [POS_W-1:0]  tail_off;
  logic [TAIL_W-1:0] tail_sh;

  always_comb begin
    tail_off = pos_i - DATA_END;
    tail_sh  = tail << tail_off;
    if (!busy_i) begin
      out_bit_o   = 1'b0;
      out_valid_o = 1'b0;
    end else if (field_i == FLD_DATA) begin
      out_bit_o   = in_bit_i;
      out_valid_o = in_valid_i;
    end else begin
      out_bit_o   = tail_sh[TAIL_W-1];
      out_valid_o = 1'b1;
    end
  end

  p_flush_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && field_i == FLD_FLUSH |-> !out_bit_o);
  p_const_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && field_i != FLD_DATA |-> out_valid_o);
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm
  import tfa_pkg::*;
#(
  parameter int DATA_BITS  = 48,
  parameter int SIG_BITS   = 4,
  parameter int DUMMY_BITS = 4,
  parameter int FLUSH_BITS = 8,
  parameter logic [SIG_BITS-1:0]   SIG_VAL   = 4'b1011,
  parameter logic [DUMMY_BITS-1:0] DUMMY_VAL = 4'b0011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic in_bit_i,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic out_bit_o,
  output logic out_valid_o,
  input  logic out_ready_i,
  output logic out_first_o,
  output logic out_last_o
);
  localparam int FRAME_BITS = DATA_BITS + SIG_BITS + DUMMY_BITS + FLUSH_BITS;
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic             busy;
  logic [POS_W-1:0] pos;
  tfa_field_e       field;
  logic             adv;

  assign adv = out_valid_o && out_ready_i;

  tfa_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sof_i (sof_i),
    .adv_i (adv),
    .busy_o(busy),
    .pos_o (pos)
  );

  tfa_field_dec #(
    .DATA_BITS(DATA_BITS), .SIG_BITS(SIG_BITS),
    .DUMMY_BITS(DUMMY_BITS), .FLUSH_BITS(FLUSH_BITS)
  ) u_dec (
    .pos_i  (pos),
    .field_o(field)
  );

  tfa_bit_mux #(
    .DATA_BITS(DATA_BITS), .SIG_BITS(SIG_BITS),
    .DUMMY_BITS(DUMMY_BITS), .FLUSH_BITS(FLUSH_BITS),
    .SIG_VAL(SIG_VAL), .DUMMY_VAL(DUMMY_VAL)
  ) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .pos_i      (pos),
    .field_i    (field),
    .in_bit_i   (in_bit_i),
    .in_valid_i (in_valid_i),
    .out_bit_o  (out_bit_o),
    .out_valid_o(out_valid_o)
  );

  assign in_ready_o  = busy && (field == FLD_DATA) && out_ready_i;
  assign out_first_o = busy && (pos == '0);
  assign out_last_o  = busy && (pos == LAST_POS);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !out_valid_o && !in_ready_o && !out_first_o && !out_last_o);
  p_ready_in_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i && !out_last_o);
  p_markers_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_first_o && out_last_o));
  p_hold_const_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && field != FLD_DATA |=> out_valid_o && $stable(out_bit_o));
  p_end_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o && adv |=> !out_valid_o && !out_first_o);
endmodule

// File: tb/tb_tx_frame_asm.sv
module tb_tx_frame_asm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, in_bit = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_bit, out_valid, out_first, out_last;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tx_frame_asm dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof),
    .in_bit_i(in_bit), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_bit_o(out_bit), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_first_o(out_first), .out_last_o(out_last)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic [47:0] d);
    logic [3:0] s = 4'b1011;
    logic [3:0] m = 4'b0011;
    if (k < 48) return d[k];
    if (k < 52) return s[51 - k];
    if (k < 56) return m[55 - k];
    return 1'b0;
  endfunction

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sof = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
      #1;
      check("R10", "idle out_valid", out_valid, 0);
      check("R1", "idle in_ready", in_ready, 0);
      check("R1", "idle markers", {out_first, out_last}, 0);
    end
  endtask

  task automatic run_frame(input int mode, input int seed);
    logic [47:0] data;
    int k = 0;
    int cyc = 0;
    logic ev;
    data = 48'hA5C3_1F0E_9B72 ^ (48'(seed) * 48'h0001_2345_6789);
    @(negedge clk);
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    while (k < 64 && cyc < 2000) begin
      in_valid  = (mode == 1 || mode == 3) ? (cyc % 3 != 0) : 1'b1;
      out_ready = (mode == 2 || mode == 3) ? (cyc % 4 != 1) : 1'b1;
      in_bit    = in_valid ? data[k % 48] : ~data[k % 48];
      sof       = (mode == 3) && (k == 20 || k == 63);
      #1;
      ev = (k < 48) ? in_valid : 1'b1;
      check("R8", "out_valid", out_valid, ev);
      check("R3", "in_ready", in_ready, (k < 48) && out_ready);
      if (ev) begin
        if (k < 48)      check("R3", $sformatf("data bit %0d", k), out_bit, exp_bit(k, data));
        else if (k < 52) check("R4", $sformatf("sig bit %0d", k), out_bit, exp_bit(k, data));
        else if (k < 56) check("R5", $sformatf("dummy bit %0d", k), out_bit, exp_bit(k, data));
        else             check("R6", $sformatf("flush bit %0d", k), out_bit, 0);
      end
      check("R7", "first", out_first, k == 0);
      check("R7", "last", out_last, k == 63);
      if (ev && out_ready) k++;
      else if (k >= 48) check("R9", "held position", out_valid, 1);
      cyc++;
      @(negedge clk);
    end
    sof = 1'b0;
    check("R2", "frame completed in bits", k, 64);
    #1;
    check("R10", "idle after frame", out_valid, 0);
    idle_check(3);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #35;
    check("R1", "reset out_valid", out_valid, 0);
    check("R1", "reset in_ready", in_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_check(2);
    for (int mode = 0; mode < 4; mode++)
      for (int seed = 0; seed < 2; seed++)
        run_frame(mode, seed * 7 + mode);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule